// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block keeps one pending-request flag per DMA channel and decides which channel, if any, gets the bus next. A channel's flag can be raised in three ways. The first is a one-cycle pulse from an on-chip peripheral. The second is an edge on an external pin. The third is a direct software trigger. A per-channel select bit chooses between the peripheral pulse and the pin. For the pin, a second bit chooses between falling edges only and both edges.

The bus alternates strictly with the CPU. The arbiter grants one channel for one transfer unit and then hands the bus back to the CPU. It waits for the CPU to finish one bus access before it grants the next pending channel, even when several channels are waiting. Among pending channels that are enabled, the lowest channel index wins. Address generation and data movement belong to the transfer engine outside this block. That engine reports the end of each unit on `unit_done_i`.

Top module: `dma_req_arb`

## Requirements
- R1: When `src_ext_i[i]`=0, a high cycle on `irq_pulse_i[i]` sets channel i's flag at the next clock edge. The grant for that channel appears one edge later at the earliest. When `src_ext_i[i]`=1, `irq_pulse_i[i]` has no effect.
- R2: When `src_ext_i[i]`=1, the synchronized `ext_pin_i[i]` sets the flag. With `both_edge_i[i]`=0 only a 1-to-0 transition sets it. With `both_edge_i[i]`=1 either transition sets it.
- R3: A channel's flag clears at the edge where that channel is granted. One request yields exactly one transfer unit.
- R4: Channel i is disabled when its mode field `xfer_mode_i[2i+1:2i]` is 00 and `cnt_zero_i[i]`=1. While it is disabled, its flag is held clear, so a pending request is dropped.
- R5: When several enabled channels are pending while the CPU owns the bus, the lowest index is granted. `grant_o` is one-hot or zero, and bit i means channel i.
- R6: A grant stays asserted until `unit_done_i`. It then drops at the next edge, and `cpu_owns_o` returns to 1. No new grant is issued until `cpu_acc_done_i` has been seen, and the earliest next grant comes one edge after that.
- R7: Pins pass through a two-flop synchronizer and an edge stage. A pin edge placed before clock edge 1 produces a grant visible after clock edge 4. Edges on several channels in the same sampling period set all their flags together.
- R8: A pending channel with `ch_en_i[i]`=0 is never granted. Its flag stays set, so it is granted once the enable returns.
- R9: A high cycle on `sw_req_i[i]` sets the flag regardless of the source select.
- R10: While `rst_ni` is low, all flags are cleared, `grant_o` is 0 and `cpu_owns_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_pulse_i | input | 4 | Per-channel peripheral request pulse |
| sw_req_i | input | 4 | Per-channel software trigger |
| ext_pin_i | input | 4 | Per-channel external request pin (asynchronous) |
| src_ext_i | input | 4 | 1 selects the pin, 0 selects the peripheral pulse |
| both_edge_i | input | 4 | 1 selects both edges, 0 selects falling edges only |
| ch_en_i | input | 4 | Per-channel grant enable |
| xfer_mode_i | input | 8 | 2-bit transfer mode per channel, channel i at [2i+1:2i] |
| cnt_zero_i | input | 4 | Per-channel transfer count is zero |
| cpu_acc_done_i | input | 1 | CPU finished one bus access |
| unit_done_i | input | 1 | Granted channel finished one transfer unit |
| grant_o | output | 4 | One-hot grant, bit i means channel i |
| cpu_owns_o | output | 1 | CPU holds the bus |

## Verification
A flag stuck high would show up as a repeated grant to the same channel right after the CPU access that follows its unit. A flag stuck low would show up as a missing grant at the expected edge. Either is visible within three cycles of the request. A wrong arbiter state shows up as `cpu_owns_o` and `grant_o` disagreeing with the unit-done and CPU-done strobes on the very next edge. Errors in the synchronizer or edge logic shift or suppress grants that follow pin activity. This is visible four edges after the pin moves.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    CPU_OWNS        = 2'd0,
    WAIT_CPU_ACCESS = 2'd1,
    DMA_ACTIVE      = 2'd2
  } arb_state_e;
endpackage

// File: rtl/dma_pin_edge.sv
module dma_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic both_i,
  output logic edge_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_q;
  logic         last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[MSB-1:0], pin_i};
      last_q <= sync_q[MSB];
    end
  end

  assign edge_o = both_i ? (last_q ^ sync_q[MSB]) : (last_q & ~sync_q[MSB]);
endmodule

// File: rtl/dma_req_flag.sv
module dma_req_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic start_i,
  input  logic disable_i,
  output logic flag_o
);
  // disable dominates; a new set wins over the start clear so it is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_o <= 1'b0;
    else if (disable_i) flag_o <= 1'b0;
    else if (set_i)     flag_o <= 1'b1;
    else if (start_i)   flag_o <= 1'b0;
  end
endmodule

// File: rtl/dma_grant_fsm.sv
module dma_grant_fsm
  import dma_arb_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] pend_i,
  input  logic            cpu_acc_done_i,
  input  logic            unit_done_i,
  output logic [N_CH-1:0] start_o,
  output logic [N_CH-1:0] grant_o,
  output logic            cpu_owns_o
);
  arb_state_e      state_q, state_d;
  logic [N_CH-1:0] grant_q, grant_d;
  logic [N_CH-1:0] pick;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    grant_d = grant_q;
    start_o = '0;
    unique case (state_q)
      CPU_OWNS: begin
        if (|pend_i) begin
          state_d = DMA_ACTIVE;
          grant_d = pick;
          start_o = pick;
        end
      end
      DMA_ACTIVE: begin
        if (unit_done_i) begin
          state_d = WAIT_CPU_ACCESS;
          grant_d = '0;
        end
      end
      WAIT_CPU_ACCESS: begin
        if (cpu_acc_done_i) state_d = CPU_OWNS;
      end
      default: begin
        state_d = CPU_OWNS;
        grant_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CPU_OWNS;
      grant_q <= '0;
    end else begin
      state_q <= state_d;
      grant_q <= grant_d;
    end
  end

  assign grant_o    = grant_q;
  assign cpu_owns_o = (state_q != DMA_ACTIVE);
endmodule

// File: rtl/dma_req_arb.sv
module dma_req_arb #(
  parameter int N_CH        = 4,
  parameter int MODE_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_CH-1:0]        irq_pulse_i,
  input  logic [N_CH-1:0]        sw_req_i,
  input  logic [N_CH-1:0]        ext_pin_i,
  input  logic [N_CH-1:0]        src_ext_i,
  input  logic [N_CH-1:0]        both_edge_i,
  input  logic [N_CH-1:0]        ch_en_i,
  input  logic [N_CH*MODE_W-1:0] xfer_mode_i,
  input  logic [N_CH-1:0]        cnt_zero_i,
  input  logic                   cpu_acc_done_i,
  input  logic                   unit_done_i,
  output logic [N_CH-1:0]        grant_o,
  output logic                   cpu_owns_o
);
  logic [N_CH-1:0] pin_edge;
  logic [N_CH-1:0] set_req;
  logic [N_CH-1:0] ch_off;
  logic [N_CH-1:0] start;
  logic [N_CH-1:0] flag_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    dma_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (ext_pin_i[g]),
      .both_i(both_edge_i[g]),
      .edge_o(pin_edge[g])
    );

    assign set_req[g] = sw_req_i[g] | (src_ext_i[g] ? pin_edge[g] : irq_pulse_i[g]);
    assign ch_off[g]  = (xfer_mode_i[g*MODE_W +: MODE_W] == '0) & cnt_zero_i[g];

    dma_req_flag flag_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (set_req[g]),
      .start_i  (start[g]),
      .disable_i(ch_off[g]),
      .flag_o   (flag_q[g])
    );
  end

  dma_grant_fsm #(.N_CH(N_CH)) fsm_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pend_i        (flag_q & ch_en_i),
    .cpu_acc_done_i(cpu_acc_done_i),
    .unit_done_i   (unit_done_i),
    .start_o       (start),
    .grant_o       (grant_o),
    .cpu_owns_o    (cpu_owns_o)
  );
endmodule

// File: rtl/dma_req_arb_chk.sv
module dma_req_arb_chk #(
  parameter int N_CH = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [N_CH-1:0] grant_o,
  input logic            cpu_owns_o,
  input logic            unit_done_i,
  input logic [N_CH-1:0] ch_en_i,
  input logic [N_CH-1:0] flag_q
);
  localparam logic [N_CH-1:0] ONE = {{(N_CH-1){1'b0}}, 1'b1};

  // R5
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  // R6
  owner_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grant_o) |-> !cpu_owns_o);

  // R6
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|grant_o) && unit_done_i) |=> (grant_o == '0) && cpu_owns_o);

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|grant_o) && !unit_done_i) |=> $stable(grant_o));

  // R5
  priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|grant_o) |-> (((grant_o - ONE) & $past(flag_q & ch_en_i)) == '0));

  // R8
  enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|grant_o) |-> ((grant_o & ~$past(ch_en_i)) == '0));

  // R10
  always_comb begin
    if (!rst_ni) begin
      reset_state_chk: assert (grant_o == '0 && cpu_owns_o && flag_q == '0);
    end
  end
endmodule

bind dma_req_arb dma_req_arb_chk #(.N_CH(N_CH)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .grant_o    (grant_o),
  .cpu_owns_o (cpu_owns_o),
  .unit_done_i(unit_done_i),
  .ch_en_i    (ch_en_i),
  .flag_q     (flag_q)
);

// File: tb/dma_req_arb_tb_top.sv
`timescale 1ns/1ps
module dma_req_arb_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] irq = '0, sw = '0, pin = '0, src_ext = '0, both = '0;
  logic [3:0] en = 4'hF, cz = '0;
  logic [7:0] mode = 8'h55;
  logic       cpu_done = 1'b0, unit_done = 1'b0;
  logic [3:0] grant;
  logic       cpu_owns;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_req_arb dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_pulse_i(irq), .sw_req_i(sw),
    .ext_pin_i(pin), .src_ext_i(src_ext), .both_edge_i(both), .ch_en_i(en),
    .xfer_mode_i(mode), .cnt_zero_i(cz), .cpu_acc_done_i(cpu_done),
    .unit_done_i(unit_done), .grant_o(grant), .cpu_owns_o(cpu_owns)
  );

  // reference model built from the requirements
  logic [3:0] m_s0, m_s1, m_prev, m_flag, m_grant;
  int         m_st; // 0 cpu, 1 wait cpu access, 2 dma

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s0 <= '0; m_s1 <= '0; m_prev <= '0; m_flag <= '0; m_grant <= '0; m_st <= 0;
    end else begin
      logic [3:0] edg, setv, dis, elig, pick, start, fl;
      for (int i = 0; i < 4; i++) begin
        edg[i]  = both[i] ? (m_prev[i] ^ m_s1[i]) : (m_prev[i] & ~m_s1[i]);
        setv[i] = sw[i] | (src_ext[i] ? edg[i] : irq[i]);
        dis[i]  = (mode[2*i +: 2] == 2'b00) && cz[i];
      end
      elig = m_flag & en;
      pick = '0;
      for (int i = 3; i >= 0; i--) if (elig[i]) pick = 4'(1 << i);
      start = (m_st == 0 && elig != 0) ? pick : 4'b0;
      for (int i = 0; i < 4; i++)
        fl[i] = dis[i] ? 1'b0 : setv[i] ? 1'b1 : start[i] ? 1'b0 : m_flag[i];
      m_flag <= fl;
      case (m_st)
        0: if (elig != 0) begin m_st <= 2; m_grant <= pick; end
        2: if (unit_done) begin m_st <= 1; m_grant <= '0; end
        default: if (cpu_done) m_st <= 0;
      endcase
      m_prev <= m_s1; m_s1 <= m_s0; m_s0 <= pin;
    end
  end

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_unit();
    unit_done = 1'b1;
    @(negedge clk); unit_done = 1'b0; cpu_done = 1'b1;
    @(negedge clk); cpu_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R6 actual=running expected=finished");
    report();
  end

  initial begin
    void'($urandom(32'd4177));
    repeat (3) @(negedge clk);
    // R10
    chk("R10 grant", grant, 4'b0);
    chk("R10 owner", {3'b0, cpu_owns}, 4'b1);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 simultaneous internal requests, R1 latency, R6 alternation
    irq = 4'b0011;
    @(negedge clk); irq = '0;
    chk("R1 no grant yet", grant, 4'b0);
    @(negedge clk);
    chk("R5 highest first", grant, 4'b0001);
    chk("R6 dma owns", {3'b0, cpu_owns}, 4'b0);
    @(negedge clk);
    chk("R6 grant held", grant, 4'b0001);
    unit_done = 1'b1;
    @(negedge clk); unit_done = 1'b0;
    chk("R6 released", grant, 4'b0);
    chk("R6 cpu owns", {3'b0, cpu_owns}, 4'b1);
    @(negedge clk);
    chk("R6 wait cpu access", grant, 4'b0);
    cpu_done = 1'b1;
    @(negedge clk); cpu_done = 1'b0;
    chk("R6 no grant on cpu done edge", grant, 4'b0);
    @(negedge clk);
    chk("R5 second channel", grant, 4'b0010);
    finish_unit();
    chk("R3 flag cleared on start", grant, 4'b0);
    repeat (2) @(negedge clk);
    chk("R3 no repeat grant", grant, 4'b0);

    // R8 enable gating
    en[2] = 1'b0; irq[2] = 1'b1;
    @(negedge clk); irq = '0;
    repeat (4) @(negedge clk);
    chk("R8 disabled enable", grant, 4'b0);
    en[2] = 1'b1;
    @(negedge clk);
    chk("R8 flag kept", grant, 4'b0100);
    finish_unit();
    chk("R8 done", grant, 4'b0);

    // R4 disable condition drops request
    en[3] = 1'b0; irq[3] = 1'b1;
    @(negedge clk); irq = '0; mode[7:6] = 2'b00; cz[3] = 1'b1;
    @(negedge clk); mode[7:6] = 2'b01; cz[3] = 1'b0; en[3] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 request dropped", grant, 4'b0);

    // R2 falling only, R1 pulse ignored, R7 latency
    src_ext[0] = 1'b1; both[0] = 1'b0;
    pin[0] = 1'b1; irq[0] = 1'b1;
    @(negedge clk); irq = '0;
    repeat (5) @(negedge clk);
    chk("R2 rising ignored / R1 pulse ignored", grant, 4'b0);
    pin[0] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 not before edge 4", grant, 4'b0);
    @(negedge clk);
    chk("R7 falling grant", grant, 4'b0001);
    finish_unit();
    chk("R2 single grant", grant, 4'b0);

    // R2 both edges
    src_ext[1] = 1'b1; both[1] = 1'b1; pin[1] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 rising with both", grant, 4'b0010);
    finish_unit();
    chk("R2 done", grant, 4'b0);

    // R7 simultaneous pin edges
    src_ext[3:2] = 2'b11; both[3:2] = 2'b11; pin[3:2] = 2'b11;
    repeat (4) @(negedge clk);
    chk("R7 first of pair", grant, 4'b0100);
    finish_unit();
    chk("R7 second of pair", grant, 4'b1000);
    finish_unit();
    chk("R7 pair done", grant, 4'b0);

    // R9 software trigger
    sw[3] = 1'b1;
    @(negedge clk); sw = '0;
    @(negedge clk);
    chk("R9 sw trigger", grant, 4'b1000);
    finish_unit();

    // constrained random against the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      chk("R5 random grant", grant, m_grant);
      chk("R6 random owner", {3'b0, cpu_owns}, {3'b0, m_st != 2});
      irq       = 4'($urandom & $urandom & $urandom);
      sw        = 4'($urandom & $urandom & $urandom & $urandom);
      pin       = pin ^ 4'($urandom & $urandom);
      en        = ~4'($urandom & $urandom & $urandom);
      cz        = 4'($urandom & $urandom);
      mode      = 8'($urandom | $urandom);
      unit_done = ($urandom % 3) == 0;
      cpu_done  = ($urandom % 2) == 0;
      if ((n % 250) == 0) begin
        src_ext = 4'($urandom);
        both    = 4'($urandom);
      end
    end
    report();
  end
endmodule